// File: doc/BRIEF.md
# Status Register and Write-Permission Guard

This block sits beside the command engine of a serial nonvolatile memory. It keeps the 8-bit status byte that the host reads back. It also decides, cycle by cycle, whether the byte now addressed may be written into the array and whether a status load may land. The command engine gives it single-cycle strobes as each command is recognised, a strobe when chip select rises, the level of the external write-protect pin, the current array address and the status byte being loaded.

The status byte is laid out as follows, from the top bit down:
- bit 7 is a lock bit that makes status loads depend on the protect pin;
- bits 6 to 4 are spare bits that can be written and read back;
- bits 3:2 form a two-bit guard field that selects the protected part of the array;
- bit 1 is the write-enable latch;
- bit 0 always reads 0.

Bits 7 to 2 model nonvolatile storage. They take a parameter value at reset.

The write-enable latch is the gate for every write. It is set and cleared by commands. It also drops when chip select rises after a write command or a status-load command has been recognised. Array permission is decided from the address of each byte, so a streaming write that wraps into a guarded range has those bytes refused one at a time.

Top module: `sreg_guard`

## Requirements
- R1: After reset the status byte reads `{NV_RESET[7:2], 0, 0}`, so the latch (bit 1) is 0 and bit 0 is 0.
- R2: A set-latch strobe makes status bit 1 read 1 from the next cycle.
- R3: A clear-latch strobe makes status bit 1 read 0 from the next cycle, and it wins over a set strobe in the same cycle.
- R4: After a recognised array-write or status-load command, the latch stays set until the next chip-select-rise strobe, which clears it.
- R5: A chip-select rise that does not follow a recognised write command leaves the latch unchanged. This covers a command aborted before recognition.
- R6: A permitted status load copies data bits 7:2 into status bits 7:2 on the next cycle. Data bits 1 and 0 are ignored: bit 1 keeps the latch value and bit 0 stays 0.
- R7: `status_we_o` is 1 exactly when the latch is 1 and either the lock bit (bit 7) is 0 or `hw_unlock_i` is 1.
- R8: The guard field (bits 3:2) selects the protected addresses, with A = 2^ADDR_W:
  - 00: no address is protected;
  - 01: addresses at or above 3A/4 are protected;
  - 10: addresses at or above A/2 are protected;
  - 11: every address is protected.
- R9: `array_we_o` is 1 exactly when the latch is 1 and `waddr_i` is outside the protected range.
- R10: A status load that is refused leaves status bits 7:2 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_latch_i | input | 1 | Strobe: set-latch command recognised |
| clr_latch_i | input | 1 | Strobe: clear-latch command recognised |
| sreg_cmd_i | input | 1 | Strobe: status-load command recognised |
| mem_cmd_i | input | 1 | Strobe: array-write command recognised |
| cs_rise_i | input | 1 | Strobe: chip select has risen |
| hw_unlock_i | input | 1 | Write-protect pin level (1 = status loads unlocked) |
| waddr_i | input | ADDR_W | Array address of the current write byte |
| sr_load_i | input | 1 | Strobe: status data byte complete |
| sr_data_i | input | 8 | Status data byte |
| status_o | output | 8 | Status byte |
| array_we_o | output | 1 | Array write permitted at `waddr_i` |
| status_we_o | output | 1 | Status load permitted |

## Verification
The address guard is swept over every address of a 6-bit array, for all four guard codes and both latch states. This separates a wrong boundary, such as an off-by-one or a swapped half and quarter, from a wrong latch gate. The status permission is tried in all eight combinations of latch, lock bit and pin. Each combination is followed by a load attempt, so a permission error shows up both on `status_we_o` and in the stored byte. The latch sequences are kept apart from one another: set, clear, set and clear together, chip-select rise with and without a prior recognised write, and a load that drives ones into bits 1 and 0.

// File: rtl/sreg_guard_pkg.sv
package sreg_guard_pkg;

  localparam int unsigned SR_W      = 8;
  localparam int unsigned LOCK_BIT  = 7;
  localparam int unsigned GUARD_HI  = 3;
  localparam int unsigned GUARD_LO  = 2;
  localparam int unsigned LATCH_BIT = 1;

  // Bits held by the nonvolatile store (7..2).
  localparam logic [SR_W-1:0] STORE_MASK = 8'hFC;

  typedef enum logic [1:0] {
    GUARD_NONE    = 2'b00,
    GUARD_QUARTER = 2'b01,
    GUARD_HALF    = 2'b10,
    GUARD_ALL     = 2'b11
  } guard_e;

  // A status load is allowed when the latch is set and either the lock
  // bit is clear or the pin unlocks it.
  function automatic logic status_permit(input logic latch, input logic lock,
                                         input logic pin);
    return latch && (!lock || pin);
  endfunction

  // Assemble the visible byte from the stored bits and the latch.
  function automatic logic [SR_W-1:0] pack_status(input logic [SR_W-1:0] store,
                                                  input logic latch);
    logic [SR_W-1:0] v;
    v = store & STORE_MASK;
    v[LATCH_BIT] = latch;
    return v;
  endfunction

endpackage

// File: rtl/sreg_guard_latch.sv
module sreg_guard_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic sreg_cmd_i,
  input  logic mem_cmd_i,
  input  logic cs_rise_i,
  output logic latch_o,
  output logic armed_o,
  output logic drop_o
);

  logic latch_q;
  logic armed_q;
  logic recog;

  assign recog  = sreg_cmd_i || mem_cmd_i;
  // A rise of chip select drops the latch only once a write command has
  // been recognised in this selection.
  assign drop_o = cs_rise_i && (armed_q || recog);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (clr_i || drop_o) begin
        latch_q <= 1'b0;
      end else if (set_i) begin
        latch_q <= 1'b1;
      end
      if (cs_rise_i) begin
        armed_q <= 1'b0;
      end else if (recog) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign latch_o = latch_q;
  assign armed_o = armed_q;

endmodule

// File: rtl/sreg_guard_store.sv
module sreg_guard_store
  import sreg_guard_pkg::*;
#(
  parameter logic [SR_W-1:0] NV_RESET = 8'h00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            permit_i,
  input  logic [SR_W-1:0] data_i,
  output logic [SR_W-1:0] store_o,
  output logic            commit_o
);

  localparam logic [SR_W-1:0] RST_VAL = NV_RESET & STORE_MASK;

  logic [SR_W-1:0] store_q;

  assign commit_o = load_i && permit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= RST_VAL;
    end else if (commit_o) begin
      store_q <= (store_q & ~STORE_MASK) | (data_i & STORE_MASK);
    end
  end

  assign store_o = store_q;

endmodule

// File: rtl/sreg_guard_region.sv
module sreg_guard_region
  import sreg_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        guard_i,
  output logic              guarded_o
);

  localparam logic [ADDR_W-1:0] HALF_BASE    = {2'b10, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] QUARTER_BASE = {2'b11, {(ADDR_W-2){1'b0}}};

  always_comb begin
    unique case (guard_e'(guard_i))
      GUARD_NONE:    guarded_o = 1'b0;
      GUARD_QUARTER: guarded_o = (addr_i >= QUARTER_BASE);
      GUARD_HALF:    guarded_o = (addr_i >= HALF_BASE);
      default:       guarded_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
  import sreg_guard_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 17,
  parameter logic [7:0]      NV_RESET = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_latch_i,
  input  logic              clr_latch_i,
  input  logic              sreg_cmd_i,
  input  logic              mem_cmd_i,
  input  logic              cs_rise_i,
  input  logic              hw_unlock_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              sr_load_i,
  input  logic [7:0]        sr_data_i,
  output logic [7:0]        status_o,
  output logic              array_we_o,
  output logic              status_we_o
);

  logic            latch_q;
  logic            latch_armed;
  logic            latch_drop;
  logic [SR_W-1:0] store_q;
  logic            store_commit;
  logic            addr_guarded;
  logic            lock_bit;
  logic [1:0]      guard_field;

  sreg_guard_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_latch_i),
    .clr_i      (clr_latch_i),
    .sreg_cmd_i (sreg_cmd_i),
    .mem_cmd_i  (mem_cmd_i),
    .cs_rise_i  (cs_rise_i),
    .latch_o    (latch_q),
    .armed_o    (latch_armed),
    .drop_o     (latch_drop)
  );

  sreg_guard_store #(.NV_RESET(NV_RESET)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (sr_load_i),
    .permit_i (status_we_o),
    .data_i   (sr_data_i),
    .store_o  (store_q),
    .commit_o (store_commit)
  );

  assign lock_bit    = store_q[LOCK_BIT];
  assign guard_field = store_q[GUARD_HI:GUARD_LO];

  sreg_guard_region #(.ADDR_W(ADDR_W)) u_region (
    .addr_i    (waddr_i),
    .guard_i   (guard_field),
    .guarded_o (addr_guarded)
  );

  assign status_we_o = status_permit(latch_q, lock_bit, hw_unlock_i);
  assign array_we_o  = latch_q && !addr_guarded;
  assign status_o    = pack_status(store_q, latch_q);

endmodule

// File: rtl/sreg_guard_chk.sv
module sreg_guard_chk #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              set_latch_i,
  input logic              clr_latch_i,
  input logic              sreg_cmd_i,
  input logic              mem_cmd_i,
  input logic              cs_rise_i,
  input logic              hw_unlock_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic              sr_load_i,
  input logic [7:0]        sr_data_i,
  input logic [7:0]        status_o,
  input logic              array_we_o,
  input logic              status_we_o,
  input logic              latch_armed
);

  a_r2_set_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (set_latch_i && !clr_latch_i && !cs_rise_i) |=> status_o[1]);

  a_r3_clear_latch: assert property (@(posedge clk) disable iff (!rst_n)
    clr_latch_i |=> !status_o[1]);

  a_r4_rise_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_i && latch_armed) |=> !status_o[1]);

  a_r5_plain_rise_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_i && !latch_armed && !sreg_cmd_i && !mem_cmd_i &&
     !set_latch_i && !clr_latch_i) |=> $stable(status_o[1]));

  a_r6_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_load_i && status_we_o) |=> (status_o[7:2] == $past(sr_data_i[7:2])));

  a_r7_status_gate: assert property (@(posedge clk) disable iff (!rst_n)
    status_we_o |-> (status_o[1] && (!status_o[7] || hw_unlock_i)));

  a_r8_all_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3:2] == 2'b11) |-> !array_we_o);

  a_r9_array_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    array_we_o |-> status_o[1]);

  a_r10_refused_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_load_i && !status_we_o) |=> $stable(status_o[7:2]));

  // R6: bit 0 never reads 1
  always @(negedge clk) begin
    if (rst_n) begin
      a_r6_bit0_low: assert (status_o[0] == 1'b0);
    end
  end

endmodule

bind sreg_guard sreg_guard_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_sreg_guard.sv
`timescale 1ns/1ps
module tb_sreg_guard;

  localparam int AW = 6;
  localparam int ASZ = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_latch_i = 0, clr_latch_i = 0, sreg_cmd_i = 0, mem_cmd_i = 0;
  logic cs_rise_i = 0, hw_unlock_i = 0, sr_load_i = 0;
  logic [AW-1:0] waddr_i = '0;
  logic [7:0] sr_data_i = '0;
  logic [7:0] status_o;
  logic array_we_o, status_we_o;

  int n_vec = 0;
  int n_bad = 0;

  // bench model
  logic       m_latch = 0;
  logic [7:0] m_nv = 8'h00;

  always #5 clk = ~clk;

  sreg_guard #(.ADDR_W(AW), .NV_RESET(8'h00)) dut (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return (m_nv & 8'hFC) | {6'b0, m_latch, 1'b0};
  endfunction

  function automatic logic exp_guard(input int g, input int a);
    int bound;
    bound = (g == 0) ? ASZ : (g == 1) ? (ASZ * 3) / 4 : (g == 2) ? ASZ / 2 : 0;
    return a >= bound;
  endfunction

  task automatic do_set();
    set_latch_i = 1; step(); set_latch_i = 0; m_latch = 1;
  endtask

  task automatic do_clr();
    clr_latch_i = 1; step(); clr_latch_i = 0; m_latch = 0;
  endtask

  // Full status-load command: optional set, recognise, data, chip select rise.
  task automatic load_sr(input logic with_set, input logic [7:0] d);
    logic ok;
    if (with_set) do_set();
    sreg_cmd_i = 1; step(); sreg_cmd_i = 0;
    ok = m_latch && (!m_nv[7] || hw_unlock_i);
    sr_data_i = d; sr_load_i = 1; step(); sr_load_i = 0;
    if (ok) m_nv = d & 8'hFC;
    cs_rise_i = 1; step(); cs_rise_i = 0;
    m_latch = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    @(negedge clk);
    check("R1 reset status", status_o, 8'h00);
    check("R1 reset array_we", array_we_o, 0);

    do_set(); @(negedge clk);
    check("R2 set latch", status_o[1], 1);
    do_clr(); @(negedge clk);
    check("R3 clear latch", status_o[1], 0);
    set_latch_i = 1; clr_latch_i = 1; step(); set_latch_i = 0; clr_latch_i = 0;
    @(negedge clk);
    check("R3 clear wins over set", status_o[1], 0);

    do_set();
    mem_cmd_i = 1; step(); mem_cmd_i = 0; @(negedge clk);
    check("R4 latch held after write recognised", status_o[1], 1);
    step(); @(negedge clk);
    check("R4 latch held until rise", status_o[1], 1);
    cs_rise_i = 1; step(); cs_rise_i = 0; m_latch = 0; @(negedge clk);
    check("R4 rise clears latch", status_o[1], 0);

    do_set();
    cs_rise_i = 1; step(); cs_rise_i = 0; @(negedge clk);
    check("R5 plain rise keeps latch", status_o[1], 1);
    cs_rise_i = 1; step(); cs_rise_i = 0; @(negedge clk);
    check("R5 second plain rise keeps latch", status_o[1], 1);
    do_clr();

    hw_unlock_i = 1;
    load_sr(1, 8'h73); @(negedge clk);
    check("R6 load ignores bits 1:0", status_o, exp_status());
    load_sr(1, 8'hFF); @(negedge clk);
    check("R6 load all ones", status_o, exp_status());
    load_sr(0, 8'h00); @(negedge clk);
    check("R10 refused without latch", status_o, exp_status());

    // R7 / R10 permission matrix
    for (int lk = 0; lk < 2; lk++) begin
      for (int pin = 0; pin < 2; pin++) begin
        for (int lt = 0; lt < 2; lt++) begin
          hw_unlock_i = 1;
          load_sr(1, lk ? 8'h80 : 8'h00);
          hw_unlock_i = pin[0];
          if (lt != 0) do_set();
          @(negedge clk);
          check("R7 status permission", status_we_o,
                (lt != 0) && (lk == 0 || pin != 0));
          step();
          sr_data_i = {lk[0], 7'h54}; sr_load_i = 1; step(); sr_load_i = 0;
          if ((lt != 0) && (lk == 0 || pin != 0)) m_nv = {lk[0], 7'h54} & 8'hFC;
          @(negedge clk);
          check("R10 load result per permission", status_o, exp_status());
          cs_rise_i = 1; mem_cmd_i = 1; step(); cs_rise_i = 0; mem_cmd_i = 0;
          m_latch = 0;
        end
      end
    end

    // R8 / R9 address sweep
    hw_unlock_i = 1;
    for (int g = 0; g < 4; g++) begin
      load_sr(1, 8'(g << 2));
      for (int lt = 0; lt < 2; lt++) begin
        if (lt != 0) do_set();
        for (int a = 0; a < ASZ; a++) begin
          waddr_i = AW'(a); #1;
          check((lt != 0) ? "R8 guard range" : "R9 latch gates array",
                array_we_o, (lt != 0) && !exp_guard(g, a));
        end
      end
      do_clr();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule